// File: doc/BRIEF.md
# Program ROM Bank Address Translator

This block turns a CPU address in the upper half of a cartridge's address space into a program ROM bank number, or a work RAM select, for one 8 KiB window at a time. Software sets four 8-bit bank registers and one mode register with ordinary CPU writes. The mode picks one of four layouts: one 32 KiB bank, two 16 KiB banks, four 8 KiB banks, or four 8 KiB banks whose numbers are read with their low seven bits mirrored. A second mode bit picks where the topmost bank comes from. A third mode bit makes the 0x6000–0x7FFF window map ROM instead of work RAM.

An outer AND mask and OR mask, driven from ports, bound every ROM bank number. This lets a multicart board confine one game to its own slice of a larger ROM. The result is always given in 8 KiB units, so the memory side needs a single bank width. The result is registered: the bank and selects for the address present at one rising edge appear just after that edge.

Top module: `prg_bank_xlate`

## Requirements
- R1: A write with address 0x8000–0x87FF loads bank register addr[1:0] with the write data. A write with address 0x8800–0x8FFF changes no bank register.
- R2: A write with address 0xD000–0xD7FF and addr[1:0]==0 loads the mode register. Writes in that range with addr[1:0]!=0 leave the mode unchanged. Mode bits: [1:0] layout, [2] last-bank source, [7] ROM at 0x6000.
- R3: After synchronous reset, all four bank registers and the mode register are zero, and bank_out, rom_sel and ram_sel are zero while reset is held.
- R4: With layout 0, any address in 0x8000–0xFFFF gives rom_sel=1 and bank_out = (((last & (AND>>2)) | (OR>>2)) << 2) | addr[14:13].
- R5: With layout 1, 0x8000–0xBFFF uses bank register 1 and 0xC000–0xFFFF uses the last bank. Each gives bank_out = (((src & (AND>>1)) | (OR>>1)) << 1) | addr[13].
- R6: With layout 2, the windows at 0x8000, 0xA000 and 0xC000 use bank registers 0, 1 and 2, and 0xE000 uses the last bank, each as (src & AND) | OR.
- R7: With layout 3, the mapping is as in R6, but each source is first reversed: bit 0 swaps with bit 6, bit 1 with bit 5 and bit 2 with bit 4, bit 3 stays, and bit 7 becomes 0.
- R8: The last bank is bank register 3 when mode bit 2 is 1, and 0xFF otherwise.
- R9: With mode bit 7 set, an address in 0x6000–0x7FFF gives rom_sel=1 and bank_out = (p & AND) | OR. Here p is the 8-bit truncation of (reg3<<2)|3 for layout 0, of (reg3<<1)|1 for layout 1, reg3 for layout 2, and reversed reg3 (as in R7) for layout 3.
- R10: With mode bit 7 clear, an address in 0x6000–0x7FFF gives rom_sel=0, ram_sel equal to ram_present, and bank_out=0.
- R11: An address below 0x6000 gives rom_sel=0, ram_sel=0 and bank_out=0. rom_sel and ram_sel are never both 1.
- R12: The outputs reflect the address, registers and mask ports sampled at a rising edge and hold until the next edge. A new address every cycle yields a new result every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Write strobe, one cycle per CPU write |
| cpu_addr | input | 16 | CPU address, used for both writes and translation |
| cpu_wdata | input | 8 | CPU write data |
| and_mask | input | 9 | Outer AND mask for ROM bank numbers |
| or_mask | input | 9 | Outer OR mask for ROM bank numbers |
| ram_present | input | 1 | Work RAM fitted on the board |
| bank_out | output | 11 | ROM bank number in 8 KiB units |
| rom_sel | output | 1 | Address maps to program ROM |
| ram_sel | output | 1 | Address maps to work RAM |

## Verification
The bench covers the window seams where a wrong shift shows first. In 32 KiB and 16 KiB layouts, an adder that forgot to append addr[14:13] or addr[13] would return the same bank for every window. Mixing AND/OR masks whose shifted forms differ would expose masks that are not shifted. The bench drives reversal patterns with distinct bits 0, 3 and 7, so a mirror that misses bit 3 or leaks bit 7 gives a visibly different number. The 0x6000 derivation is run in every layout, with a register 3 value whose top bits a design that fails to truncate would carry into the result. It probes writes to the ignored bank range and to the mode address with a nonzero low field, where a loose decoder would corrupt later translations. The top bank is sampled with the last-bank source both set and clear.

// File: rtl/prg_xlate_pkg.sv
package prg_xlate_pkg;

  typedef enum logic [1:0] {
    LAYOUT_32K     = 2'd0,
    LAYOUT_16K     = 2'd1,
    LAYOUT_8K      = 2'd2,
    LAYOUT_8K_FLIP = 2'd3
  } layout_e;

  // mode register bit positions
  localparam int MODE_LAST_BIT = 2;
  localparam int MODE_ROM6_BIT = 7;

  // address pages (top five address bits) decoded by the register file
  localparam logic [4:0] PAGE_BANK = 5'b10000;  // 0x8000-0x87FF
  localparam logic [4:0] PAGE_MODE = 5'b11010;  // 0xD000-0xD7FF

  // windows below the upper half of the address space (top three bits)
  localparam logic [2:0] WIN_LOW_RAM = 3'b011;  // 0x6000-0x7FFF

endpackage

// File: rtl/prg_bit_flip.sv
module prg_bit_flip #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // mirror bits [W-2:0] around their centre, clear the top bit
  genvar b;
  generate
    for (b = 0; b < W - 1; b++) begin : g_flip
      assign dout[b] = din[W-2-b];
    end
  endgenerate
  assign dout[W-1] = 1'b0;
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cpu_we,
  input  logic [ADDR_W-1:0]                  cpu_addr,
  input  logic [REG_W-1:0]                   cpu_wdata,
  output logic [NUM_REGS-1:0][REG_W-1:0]     bank_q,
  output logic [REG_W-1:0]                   mode_q
);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int PAGE_W = 5;

  logic [PAGE_W-1:0] page;
  logic              bank_hit;
  logic              mode_hit;

  assign page     = cpu_addr[ADDR_W-1 -: PAGE_W];
  assign bank_hit = cpu_we && (page == PAGE_BANK);
  assign mode_hit = cpu_we && (page == PAGE_MODE) && (cpu_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      mode_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (bank_hit && (cpu_addr[IDX_W-1:0] == IDX_W'(i)))
          bank_q[i] <= cpu_wdata;
      end
      if (mode_hit)
        mode_q <= cpu_wdata;
    end
  end

  p_bank_load_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[ADDR_W-1 -: PAGE_W] == PAGE_BANK)
      |=> bank_q[$past(cpu_addr[IDX_W-1:0])] == $past(cpu_wdata));

  p_skip_page_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[ADDR_W-1 -: PAGE_W] == 5'b10001) |=> $stable(bank_q));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cpu_we || cpu_addr[1:0] != 2'b00) |=> $stable(mode_q));

  p_reset_regs_r3: assert property (@(posedge clk)
    rst |=> (mode_q == '0 && bank_q == '0));

endmodule

// File: rtl/prg_bank_calc.sv
module prg_bank_calc
  import prg_xlate_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 4,
  parameter int MASK_W   = 9,
  parameter int NUM_WIN  = 4
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0]   bank_q,
  input  logic [REG_W-1:0]                 mode_q,
  input  logic [MASK_W-1:0]                and_mask,
  input  logic [MASK_W-1:0]                or_mask,
  output logic [NUM_WIN-1:0][MASK_W+1:0]   win_bank,
  output logic [MASK_W+1:0]                low_bank
);
  localparam int SRC_N = NUM_REGS + 1;   // four registers plus the last bank
  localparam int LAST  = NUM_REGS;

  function automatic logic [MASK_W-1:0] ext(input logic [REG_W-1:0] v);
    return {{(MASK_W-REG_W){1'b0}}, v};
  endfunction

  layout_e                     layout;
  logic [REG_W-1:0]            last_q;
  logic [SRC_N-1:0][REG_W-1:0] raw;
  logic [SRC_N-1:0][REG_W-1:0] flip;

  assign layout = layout_e'(mode_q[1:0]);
  assign last_q = mode_q[MODE_LAST_BIT] ? bank_q[NUM_REGS-1] : {REG_W{1'b1}};

  genvar s;
  generate
    for (s = 0; s < SRC_N; s++) begin : g_src
      if (s < NUM_REGS) begin : g_reg
        assign raw[s] = bank_q[s];
      end else begin : g_last
        assign raw[s] = last_q;
      end
      prg_bit_flip #(.W(REG_W)) u_flip (.din(raw[s]), .dout(flip[s]));
    end
  endgenerate

  logic [MASK_W-1:0] b32, b16lo, b16hi, b8, low_m;
  logic [REG_W-1:0]  sel8, p6;

  always_comb begin
    b32   = (ext(last_q)    & (and_mask >> 2)) | (or_mask >> 2);
    b16lo = (ext(bank_q[1]) & (and_mask >> 1)) | (or_mask >> 1);
    b16hi = (ext(last_q)    & (and_mask >> 1)) | (or_mask >> 1);
    sel8  = '0;
    b8    = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (layout == LAYOUT_8K_FLIP)
        sel8 = (w < NUM_WIN - 1) ? flip[w] : flip[LAST];
      else
        sel8 = (w < NUM_WIN - 1) ? raw[w] : raw[LAST];
      b8 = (ext(sel8) & and_mask) | or_mask;
      case (layout)
        LAYOUT_32K: win_bank[w] = {b32, 2'(w)};
        LAYOUT_16K: win_bank[w] = {1'b0, ((w < NUM_WIN / 2) ? b16lo : b16hi), 1'(w)};
        default:    win_bank[w] = {2'b00, b8};
      endcase
    end

    case (layout)
      LAYOUT_32K: p6 = {bank_q[NUM_REGS-1][REG_W-3:0], 2'b11};
      LAYOUT_16K: p6 = {bank_q[NUM_REGS-1][REG_W-2:0], 1'b1};
      LAYOUT_8K:  p6 = bank_q[NUM_REGS-1];
      default:    p6 = flip[NUM_REGS-1];
    endcase
    low_m    = (ext(p6) & and_mask) | or_mask;
    low_bank = {2'b00, low_m};
  end

endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import prg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 4,
  parameter int MASK_W   = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [REG_W-1:0]    cpu_wdata,
  input  logic [MASK_W-1:0]   and_mask,
  input  logic [MASK_W-1:0]   or_mask,
  input  logic                ram_present,
  output logic [MASK_W+1:0]   bank_out,
  output logic                rom_sel,
  output logic                ram_sel
);
  localparam int NUM_WIN = 4;
  localparam int WIN_W   = $clog2(NUM_WIN);
  localparam int OUT_W   = MASK_W + 2;

  logic [NUM_REGS-1:0][REG_W-1:0]  bank_q;
  logic [REG_W-1:0]                mode_q;
  logic [NUM_WIN-1:0][OUT_W-1:0]   win_bank;
  logic [OUT_W-1:0]                low_bank;
  logic [2:0]                      top3;
  logic [WIN_W-1:0]                win_idx;

  prg_bank_regs #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .bank_q(bank_q), .mode_q(mode_q)
  );

  prg_bank_calc #(
    .REG_W(REG_W), .NUM_REGS(NUM_REGS), .MASK_W(MASK_W), .NUM_WIN(NUM_WIN)
  ) u_calc (
    .bank_q(bank_q), .mode_q(mode_q), .and_mask(and_mask), .or_mask(or_mask),
    .win_bank(win_bank), .low_bank(low_bank)
  );

  assign top3    = cpu_addr[ADDR_W-1 -: 3];
  assign win_idx = cpu_addr[ADDR_W-2 -: WIN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_out <= '0;
      rom_sel  <= 1'b0;
      ram_sel  <= 1'b0;
    end else if (top3[2]) begin
      bank_out <= win_bank[win_idx];
      rom_sel  <= 1'b1;
      ram_sel  <= 1'b0;
    end else if (top3 == WIN_LOW_RAM && mode_q[MODE_ROM6_BIT]) begin
      bank_out <= low_bank;
      rom_sel  <= 1'b1;
      ram_sel  <= 1'b0;
    end else begin
      bank_out <= '0;
      rom_sel  <= 1'b0;
      ram_sel  <= (top3 == WIN_LOW_RAM) && ram_present;
    end
  end

  p_sel_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(rom_sel && ram_sel));

  p_low_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[ADDR_W-1 -: 3] < 3'b011) |=> (!rom_sel && !ram_sel && bank_out == '0));

  p_ram_cause_r10: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> ($past(ram_present) && !$past(mode_q[MODE_ROM6_BIT])));

  p_rom6_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[ADDR_W-1 -: 3] == WIN_LOW_RAM && mode_q[MODE_ROM6_BIT])
      |=> (rom_sel && !ram_sel));

  p_upper_rom_r12: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[ADDR_W-1] |=> rom_sel);

endmodule

// File: tb/test_prg_bank_xlate.sv
module test_prg_bank_xlate;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          cyc;
    logic [10:0] bank;
    logic        rom;
    logic        ram;
    string       req;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [8:0]  and_m = 9'h1FF;
  logic [8:0]  or_m = 9'h000;
  logic        ram_p = 0;
  logic [10:0] bank_out;
  logic        rom_sel, ram_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  item_t q[$];
  logic [7:0] m_bank [4];
  logic [7:0] m_mode;

  prg_bank_xlate i_prg_bank_xlate (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .and_mask(and_m), .or_mask(or_m),
    .ram_present(ram_p), .bank_out(bank_out), .rom_sel(rom_sel), .ram_sel(ram_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [10:0] ab, eb, logic ao, eo, ar, er);
    checks++;
    if (ab !== eb || ao !== eo || ar !== er) begin
      errors++;
      $display("FAIL %s actual bank=%h rom=%b ram=%b expected bank=%h rom=%b ram=%b",
               req, ab, ao, ar, eb, eo, er);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    return {1'b0, v[0], v[1], v[2], v[3], v[4], v[5], v[6]};
  endfunction

  function automatic logic [10:0] mk(logic [7:0] r, int sh);
    logic [8:0] v;
    v = ({1'b0, r} & (and_m >> sh)) | (or_m >> sh);
    return {2'b00, v};
  endfunction

  function automatic item_t expect_for(logic [15:0] a, string req);
    item_t it;
    logic [7:0] last, src, p6;
    int w;
    it.cyc = cyc; it.req = req; it.bank = '0; it.rom = 0; it.ram = 0;
    last = m_mode[2] ? m_bank[3] : 8'hFF;
    w = int'(a[14:13]);
    if (a[15]) begin
      it.rom = 1;
      case (m_mode[1:0])
        2'd0: it.bank = (mk(last, 2) << 2) | 11'(w);
        2'd1: it.bank = (mk((w < 2) ? m_bank[1] : last, 1) << 1) | 11'(w & 1);
        2'd2: begin src = (w < 3) ? m_bank[w] : last; it.bank = mk(src, 0); end
        default: begin src = (w < 3) ? m_bank[w] : last; it.bank = mk(rev8(src), 0); end
      endcase
    end else if (a[15:13] == 3'b011) begin
      if (m_mode[7]) begin
        it.rom = 1;
        case (m_mode[1:0])
          2'd0: p6 = 8'((m_bank[3] << 2) | 3);
          2'd1: p6 = 8'((m_bank[3] << 1) | 1);
          2'd2: p6 = m_bank[3];
          default: p6 = rev8(m_bank[3]);
        endcase
        it.bank = mk(p6, 0);
      end else begin
        it.ram = ram_p;
      end
    end
    return it;
  endfunction

  // driver: one bus write, bench model follows the decode rules of R1/R2
  task automatic wr(logic [15:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1;
    @(negedge clk);
    cpu_we = 0;
    if (a[15:11] == 5'b10000) m_bank[a[1:0]] = d;
    if (a[15:11] == 5'b11010 && a[1:0] == 2'b00) m_mode = d;
  endtask

  task automatic probe(logic [15:0] a, string req);
    cpu_addr = a;
    q.push_back(expect_for(a, req));
    @(negedge clk);
  endtask

  // monitor: compare one cycle after issue
  always @(negedge clk) begin
    if (!rst && q.size() > 0 && q[0].cyc + 1 == cyc) begin
      item_t it;
      it = q.pop_front();
      check(it.req, bank_out, it.bank, rom_sel, it.rom, ram_sel, it.ram);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_bank[i] = '0;
    m_mode = '0;
    repeat (3) @(negedge clk);
    check("R3", bank_out, '0, rom_sel, 0, ram_sel, 0);
    rst = 0;
    @(negedge clk);

    // R3: reset state (layout 0, last=0xFF; then zeroed registers in 8K layout)
    probe(16'hE000, "R3");
    wr(16'hD000, 8'h06);
    probe(16'h8000, "R3");
    probe(16'hE000, "R3");
    wr(16'hD000, 8'h00);

    // R4: 32 KiB layout, window bits appended, two mask settings
    for (int w = 0; w < 4; w++) probe(16'h8000 + 16'(w) * 16'h2000, "R4");
    and_m = 9'h00F; or_m = 9'h1A0;
    for (int w = 0; w < 4; w++) probe(16'h8123 + 16'(w) * 16'h2000, "R4");
    and_m = 9'h1FF; or_m = 9'h000;

    // R1: register loads, ignored range, index from low bits
    wr(16'h8000, 8'h15); wr(16'h8001, 8'h2A); wr(16'h8002, 8'h33); wr(16'h8403, 8'hCD);
    wr(16'h8800, 8'h77); wr(16'h8FFE, 8'h66);
    wr(16'hD000, 8'h06);
    probe(16'h8000, "R1"); probe(16'hA000, "R1"); probe(16'hC000, "R1"); probe(16'hE000, "R1");

    // R6 / R8: 8K layout with last = 0xFF and last = reg3
    wr(16'hD000, 8'h02);
    for (int w = 0; w < 4; w++) probe(16'h9FFF + 16'(w) * 16'h2000, "R6");
    and_m = 9'h03F; or_m = 9'h140;
    probe(16'hE000, "R8"); wr(16'hD000, 8'h06); probe(16'hE000, "R8");
    and_m = 9'h1FF; or_m = 9'h000;

    // R5: 16K layout, both last sources and shifted masks
    wr(16'hD000, 8'h01);
    for (int w = 0; w < 4; w++) probe(16'h8000 + 16'(w) * 16'h2000, "R5");
    wr(16'hD000, 8'h05); and_m = 9'h07E; or_m = 9'h081;
    for (int w = 0; w < 4; w++) probe(16'hA010 + 16'(w) * 16'h1000, "R5");
    and_m = 9'h1FF; or_m = 9'h000;

    // R7: reversed layout with distinct bit patterns
    wr(16'h8000, 8'h81); wr(16'h8001, 8'h08); wr(16'h8002, 8'h46); wr(16'h8003, 8'hF3);
    wr(16'hD000, 8'h03);
    for (int w = 0; w < 4; w++) probe(16'h8000 + 16'(w) * 16'h2000, "R7");
    wr(16'hD000, 8'h07);
    for (int w = 0; w < 4; w++) probe(16'h8000 + 16'(w) * 16'h2000, "R7");

    // R2: mode writes with nonzero low bits are ignored, mirror in range accepted
    wr(16'hD001, 8'h80); wr(16'hD003, 8'h01);
    probe(16'hE000, "R2"); probe(16'h6000, "R2");
    wr(16'hD404, 8'h02);
    probe(16'hE000, "R2");

    // R9: ROM at 0x6000 in every layout
    wr(16'h8003, 8'hE5);
    for (int m = 0; m < 4; m++) begin
      wr(16'hD000, 8'h80 | 8'(m));
      probe(16'h6000, "R9"); probe(16'h7FFF, "R9");
    end
    and_m = 9'h01F; or_m = 9'h120;
    wr(16'hD000, 8'h80); probe(16'h6ABC, "R9");
    and_m = 9'h1FF; or_m = 9'h000;

    // R10: work RAM window
    wr(16'hD000, 8'h02);
    ram_p = 1; probe(16'h6000, "R10"); probe(16'h7FFF, "R10");
    ram_p = 0; probe(16'h6000, "R10");
    ram_p = 1;

    // R11: low addresses select nothing, even with ROM-at-0x6000 set
    wr(16'hD000, 8'h82);
    probe(16'h0000, "R11"); probe(16'h5FFF, "R11"); probe(16'h4020, "R11");

    // R12: back-to-back different addresses give per-cycle results
    for (int k = 0; k < 8; k++) probe(16'(k) * 16'h2000 + 16'h0100, "R12");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R12 pending actual=%0d expected=0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule